// File: doc/BRIEF.md
# Sprite Table DMA Engine

This block copies a 160-byte sprite table from any 256-byte-aligned page of the 16-bit address space into sprite attribute memory. Software starts it by supplying the page number (the high byte of the source address). The engine then waits a fixed number of system ticks and moves one byte per fixed tick interval. It reads through a combinational memory read port and writes sprite memory through its own write port.

While a copy is in progress, the block also filters the CPU's own bus accesses. Any access that lands in the sprite page, or in the bus region the copy is reading from, is suppressed. A suppressed read returns 0xFF and a suppressed write is dropped. The region that is blocked depends on the source page and on the machine model (monochrome or color), and the model is captured when a copy starts. A start issued while a copy is running restarts the copy from the new page.

Top module: `sprite_dma`

## Requirements
- R1: A start pulse with `start_page_i` at or below 0xF1 is accepted: `busy_o` is high in the next cycle and reads come from address `start_page_i`*256 + offset. A start with a page of 0xF2 or higher is ignored: it does not change `busy_o`, the read sequence or the sprite writes.
- R2: Only clock edges with `tick_i` high count as ticks, and the tick at the accepting edge is not counted. The first byte is read at the 8th tick after the accepting edge.
- R3: Each later byte is read at the 4th tick after the previous read.
- R4: Exactly 160 bytes are copied, in source offset order 0 to 159. A read at offset n is shown by `mem_rd_en_o` high with `mem_rd_addr_o` = page*256+n. The data sampled at that edge is written in the next cycle with `spr_we_o` high, `spr_addr_o` = n and `spr_wdata_o` equal to the data.
- R5: `busy_o` is high from the cycle after an accepted start through the cycle in which byte 159 is read. The write strobe of the last byte appears in the first cycle with `busy_o` low.
- R6: While `busy_o` is high, a CPU access to a blocked address has `cpu_rd_o` and `cpu_wr_o` forced low and `cpu_rdata_o` = 0xFF. Any other access, and every access while idle, passes `cpu_rd_i`, `cpu_wr_i` and `cpu_rdata_i` through unchanged.
- R7: While `busy_o` is high, addresses 0xFE00 to 0xFEFF are always blocked.
- R8: Monochrome model (`color_mode_i` = 0 at start): a source page in 0x80 to 0x9F blocks 0x8000 to 0x9FFF. Any other source page blocks 0xA000 to 0xFDFF.
- R9: Color model (`color_mode_i` = 1 at start): a source page in 0x80 to 0x9F blocks 0x8000 to 0x9FFF, and a source page in 0xC0 to 0xDF blocks 0xC000 to 0xFDFF. Any other source page blocks 0xA000 to 0xBFFF.
- R10: The model used for blocking is the value of `color_mode_i` at the accepting edge. Later changes of that input have no effect until the next accepted start.
- R11: An accepted start during a copy restarts it from the new page at offset 0, with the first read again 8 ticks later. No write strobe appears in the cycle after the restarting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | System cycle tick qualifying the pacing counter |
| start_i | input | 1 | Start strobe |
| start_page_i | input | 8 | Source page (high byte of source address) |
| color_mode_i | input | 1 | Model select: 0 monochrome, 1 color |
| mem_rd_en_o | output | 1 | Read strobe; data is sampled at this edge |
| mem_rd_addr_o | output | 16 | Source read address |
| mem_rd_data_i | input | 8 | Combinational read data |
| spr_we_o | output | 1 | Sprite memory write strobe |
| spr_addr_o | output | 8 | Sprite memory byte offset |
| spr_wdata_o | output | 8 | Sprite memory write data |
| busy_o | output | 1 | Copy in progress |
| cpu_addr_i | input | 16 | CPU access address |
| cpu_rd_i | input | 1 | CPU read request |
| cpu_wr_i | input | 1 | CPU write request |
| cpu_rdata_i | input | 8 | Read data from the bus toward the CPU |
| cpu_rd_o | output | 1 | Filtered read request to the bus |
| cpu_wr_o | output | 1 | Filtered write request to the bus |
| cpu_rdata_o | output | 8 | Filtered read data to the CPU |

## Verification
Two conditions are hard to reach from the ports. One is a start arriving in the middle of a copy, while the pacing counter is partly through an interval. The other is the model input changing after the copy has begun. The stimulus issues both rejected and accepted starts hundreds of cycles into a running copy, with the tick thinned at random. It toggles `color_mode_i` at random on every CPU probe, and predicts blocking from the model latched at the start. Every page region is visited under both models, and boundary addresses on each side of each window are probed during each copy.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

    typedef enum logic {
        MODEL_MONO  = 1'b0,
        MODEL_COLOR = 1'b1
    } sdma_model_e;

    // blocked half-open range of address high bytes [lo, hi)
    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
    } sdma_window_t;

    localparam logic [7:0] PG_VIDEO_LO  = 8'h80;
    localparam logic [7:0] PG_VIDEO_HI  = 8'hA0;
    localparam logic [7:0] PG_EXTRAM_HI = 8'hC0;
    localparam logic [7:0] PG_WORK_END  = 8'hFE;

    localparam logic [2:0] RGN_VIDEO = 3'd4;
    localparam logic [2:0] RGN_WORK  = 3'd6;

endpackage

// File: rtl/sprite_dma_pacer.sv
module sprite_dma_pacer #(
    parameter int FIRST_DELAY = 8,
    parameter int STEP_DELAY  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic tick_i,
    output logic fire_o
);
    localparam int MAX_DELAY = (FIRST_DELAY > STEP_DELAY) ? FIRST_DELAY : STEP_DELAY;
    localparam int WAIT_W    = $clog2(MAX_DELAY + 1);

    typedef struct packed {
        logic [WAIT_W-1:0] wait_cnt;
    } pace_t;

    pace_t pace_d, pace_q;

    always_comb begin
        pace_d = pace_q;
        fire_o = run_i && tick_i && (pace_q.wait_cnt == WAIT_W'(1));
        if (restart_i) begin
            pace_d.wait_cnt = WAIT_W'(FIRST_DELAY);
        end else if (run_i && tick_i) begin
            if (fire_o) begin
                pace_d.wait_cnt = WAIT_W'(STEP_DELAY);
            end else begin
                pace_d.wait_cnt = pace_q.wait_cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pace_q <= '{wait_cnt: WAIT_W'(FIRST_DELAY)};
        end else begin
            pace_q <= pace_d;
        end
    end

endmodule

// File: rtl/sprite_dma_window.sv
module sprite_dma_window
    import sprite_dma_pkg::*;
(
    input  logic [2:0]   region_i,
    input  sdma_model_e  model_i,
    output sdma_window_t win_o
);
    sdma_window_t win_mono, win_color;

    always_comb begin
        if (region_i == RGN_VIDEO) begin
            win_mono = '{lo: PG_VIDEO_LO, hi: PG_VIDEO_HI};
        end else begin
            win_mono = '{lo: PG_VIDEO_HI, hi: PG_WORK_END};
        end

        if (region_i == RGN_VIDEO) begin
            win_color = '{lo: PG_VIDEO_LO, hi: PG_VIDEO_HI};
        end else if (region_i == RGN_WORK) begin
            win_color = '{lo: PG_EXTRAM_HI, hi: PG_WORK_END};
        end else begin
            win_color = '{lo: PG_VIDEO_HI, hi: PG_EXTRAM_HI};
        end

        win_o = (model_i == MODEL_COLOR) ? win_color : win_mono;
    end

endmodule

// File: rtl/sprite_dma_gate.sv
module sprite_dma_gate
    import sprite_dma_pkg::*;
#(
    parameter logic [7:0] SPRITE_PAGE = 8'hFE
) (
    input  logic         active_i,
    input  sdma_window_t win_i,
    input  logic [15:0]  cpu_addr_i,
    input  logic         cpu_rd_i,
    input  logic         cpu_wr_i,
    input  logic [7:0]   cpu_rdata_i,
    output logic         cpu_rd_o,
    output logic         cpu_wr_o,
    output logic [7:0]   cpu_rdata_o
);
    logic in_sprite, in_window, blocked;

    always_comb begin
        in_sprite = (cpu_addr_i >= {SPRITE_PAGE, 8'h00}) &&
                    (cpu_addr_i <= {SPRITE_PAGE, 8'hFF});
        in_window = (cpu_addr_i >= {win_i.lo, 8'h00}) &&
                    (cpu_addr_i <  {win_i.hi, 8'h00});
        blocked   = active_i && (in_sprite || in_window);

        cpu_rd_o    = cpu_rd_i && !blocked;
        cpu_wr_o    = cpu_wr_i && !blocked;
        cpu_rdata_o = blocked ? 8'hFF : cpu_rdata_i;
    end

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
    import sprite_dma_pkg::*;
#(
    parameter int         BYTE_COUNT  = 160,
    parameter int         FIRST_DELAY = 8,
    parameter int         STEP_DELAY  = 4,
    parameter logic [7:0] LAST_PAGE   = 8'hF1,
    parameter logic [7:0] SPRITE_PAGE = 8'hFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        start_i,
    input  logic [7:0]  start_page_i,
    input  logic        color_mode_i,
    output logic        mem_rd_en_o,
    output logic [15:0] mem_rd_addr_o,
    input  logic [7:0]  mem_rd_data_i,
    output logic        spr_we_o,
    output logic [7:0]  spr_addr_o,
    output logic [7:0]  spr_wdata_o,
    output logic        busy_o,
    input  logic [15:0] cpu_addr_i,
    input  logic        cpu_rd_i,
    input  logic        cpu_wr_i,
    input  logic [7:0]  cpu_rdata_i,
    output logic        cpu_rd_o,
    output logic        cpu_wr_o,
    output logic [7:0]  cpu_rdata_o
);
    localparam int OFF_W = 8;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BYTE_COUNT - 1);

    typedef struct packed {
        logic             active;
        sdma_model_e      model;
        logic [7:0]       page;
        logic [OFF_W-1:0] off;
    } core_t;

    typedef struct packed {
        logic             we;
        logic [OFF_W-1:0] addr;
        logic [7:0]       data;
    } wbuf_t;

    core_t core_d, core_q;
    wbuf_t wbuf_d, wbuf_q;

    logic         accept;
    logic         fire;
    logic         xfer;
    sdma_window_t win;

    sprite_dma_pacer #(
        .FIRST_DELAY (FIRST_DELAY),
        .STEP_DELAY  (STEP_DELAY)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .run_i     (core_q.active),
        .tick_i    (tick_i),
        .fire_o    (fire)
    );

    always_comb begin
        accept = start_i && (start_page_i <= LAST_PAGE);
        // a restart wins over a byte due at the same edge
        xfer   = fire && !accept;

        core_d = core_q;
        wbuf_d = '{we: xfer, addr: core_q.off, data: mem_rd_data_i};

        if (accept) begin
            core_d.active = 1'b1;
            core_d.model  = color_mode_i ? MODEL_COLOR : MODEL_MONO;
            core_d.page   = start_page_i;
            core_d.off    = '0;
        end else if (xfer) begin
            core_d.off = core_q.off + 1'b1;
            if (core_q.off == LAST_OFF) begin
                core_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
            wbuf_q <= '0;
        end else begin
            core_q <= core_d;
            wbuf_q <= wbuf_d;
        end
    end

    sprite_dma_window u_window (
        .region_i (core_q.page[7:5]),
        .model_i  (core_q.model),
        .win_o    (win)
    );

    sprite_dma_gate #(
        .SPRITE_PAGE (SPRITE_PAGE)
    ) u_gate (
        .active_i    (core_q.active),
        .win_i       (win),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_rd_i    (cpu_rd_i),
        .cpu_wr_i    (cpu_wr_i),
        .cpu_rdata_i (cpu_rdata_i),
        .cpu_rd_o    (cpu_rd_o),
        .cpu_wr_o    (cpu_wr_o),
        .cpu_rdata_o (cpu_rdata_o)
    );

    assign mem_rd_en_o   = xfer;
    assign mem_rd_addr_o = {core_q.page, core_q.off};
    assign spr_we_o      = wbuf_q.we;
    assign spr_addr_o    = wbuf_q.addr;
    assign spr_wdata_o   = wbuf_q.data;
    assign busy_o        = core_q.active;

endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
    parameter int         BYTE_COUNT  = 160,
    parameter logic [7:0] LAST_PAGE   = 8'hF1,
    parameter logic [7:0] SPRITE_PAGE = 8'hFE
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [7:0]  start_page_i,
    input logic        mem_rd_en_o,
    input logic [15:0] mem_rd_addr_o,
    input logic [7:0]  mem_rd_data_i,
    input logic        spr_we_o,
    input logic [7:0]  spr_addr_o,
    input logic [7:0]  spr_wdata_o,
    input logic        busy_o,
    input logic [15:0] cpu_addr_i,
    input logic        cpu_rd_i,
    input logic        cpu_wr_i,
    input logic [7:0]  cpu_rdata_i,
    input logic        cpu_rd_o,
    input logic        cpu_wr_o,
    input logic [7:0]  cpu_rdata_o
);
    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> spr_we_o && (spr_addr_o == $past(mem_rd_addr_o[7:0]))
                        && (spr_wdata_o == $past(mem_rd_data_i)));

    a_r4_offset_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (int'(mem_rd_addr_o[7:0]) < BYTE_COUNT));

    a_r1_page_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> busy_o && (mem_rd_addr_o[15:8] <= LAST_PAGE));

    a_r1_reject_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (start_page_i > LAST_PAGE)) |=> !busy_o);

    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (start_page_i <= LAST_PAGE)) |=> busy_o);

    a_r11_no_write_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (start_page_i <= LAST_PAGE)) |=> !spr_we_o && !mem_rd_en_o);

    a_r6_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cpu_rd_o == cpu_rd_i) && (cpu_wr_o == cpu_wr_i)
                    && (cpu_rdata_o == cpu_rdata_i));

    a_r6_dropped_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && !cpu_rd_o) |-> (cpu_rdata_o == 8'hFF));

    a_r7_sprite_page_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (cpu_addr_i >= {SPRITE_PAGE, 8'h00}) && (cpu_addr_i <= {SPRITE_PAGE, 8'hFF}))
        |-> !cpu_rd_o && !cpu_wr_o && (cpu_rdata_o == 8'hFF));

endmodule

bind sprite_dma sprite_dma_chk #(
    .BYTE_COUNT  (BYTE_COUNT),
    .LAST_PAGE   (LAST_PAGE),
    .SPRITE_PAGE (SPRITE_PAGE)
) u_chk (.*);

// File: tb/tb_sprite_dma.sv
module tb_sprite_dma;
    localparam int CLK_PERIOD = 10;
    localparam int BYTES      = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  start_page_i = '0;
    logic        color_mode_i = 1'b0;
    logic        mem_rd_en_o;
    logic [15:0] mem_rd_addr_o;
    logic [7:0]  mem_rd_data_i;
    logic        spr_we_o;
    logic [7:0]  spr_addr_o;
    logic [7:0]  spr_wdata_o;
    logic        busy_o;
    logic [15:0] cpu_addr_i = '0;
    logic        cpu_rd_i = 1'b0;
    logic        cpu_wr_i = 1'b0;
    logic [7:0]  cpu_rdata_i = '0;
    logic        cpu_rd_o;
    logic        cpu_wr_o;
    logic [7:0]  cpu_rdata_o;

    int checks = 0;
    int failures = 0;
    int tick_cnt = 0;
    bit dense = 1'b1;
    bit exp_run = 1'b0;
    bit exp_restart = 1'b0;
    int exp_n = 0;
    int base = 0;
    logic [7:0] exp_page = '0;
    bit exp_color = 1'b0;

    function automatic logic [7:0] pat(logic [15:0] a);
        return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h3C;
    endfunction

    // expected blocking from R6..R9, using the model latched at start (R10)
    function automatic bit exp_block(logic [7:0] page, bit color, logic [15:0] a);
        logic [7:0] hb;
        logic [2:0] rg;
        hb = a[15:8];
        rg = page[7:5];
        if (hb == 8'hFE) return 1'b1;
        if (rg == 3'd4) return (hb >= 8'h80) && (hb < 8'hA0);
        if (!color) return (hb >= 8'hA0) && (hb < 8'hFE);
        if (rg == 3'd6) return (hb >= 8'hC0) && (hb < 8'hFE);
        return (hb >= 8'hA0) && (hb < 8'hC0);
    endfunction

    assign mem_rd_data_i = pat(mem_rd_addr_o);

    sprite_dma dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
        .start_page_i(start_page_i), .color_mode_i(color_mode_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_data_i(mem_rd_data_i), .spr_we_o(spr_we_o),
        .spr_addr_o(spr_addr_o), .spr_wdata_o(spr_wdata_o), .busy_o(busy_o),
        .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i),
        .cpu_rdata_i(cpu_rdata_i), .cpu_rd_o(cpu_rd_o), .cpu_wr_o(cpu_wr_o),
        .cpu_rdata_o(cpu_rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) if (rst_n && tick_i) tick_cnt <= tick_cnt + 1;

    always @(negedge clk) tick_i <= dense ? 1'b1 : (($urandom % 3) != 0);

    // write monitor: R2, R3, R4, R5, R11
    always @(negedge clk) begin
        if (rst_n && spr_we_o) begin
            if (!exp_run) begin
                check(1'b0, "R1", "write with no copy expected", int'(spr_addr_o), -1);
            end else begin
                string treq;
                treq = exp_restart ? "R11" : ((exp_n == 0) ? "R2" : "R3");
                check(int'(spr_addr_o) == exp_n, "R4", "sprite offset", int'(spr_addr_o), exp_n);
                check(spr_wdata_o == pat({exp_page, 8'(exp_n)}), "R4", "sprite data",
                      int'(spr_wdata_o), int'(pat({exp_page, 8'(exp_n)})));
                check(tick_cnt == base + 8 + 4 * exp_n, treq, "read tick",
                      tick_cnt - base, 8 + 4 * exp_n);
                exp_n++;
                if (exp_n == BYTES) begin
                    exp_run = 1'b0;
                    check(busy_o == 1'b0, "R5", "busy after last byte", int'(busy_o), 0);
                end else begin
                    check(busy_o == 1'b1, "R5", "busy mid copy", int'(busy_o), 1);
                end
            end
        end
    end

    task automatic do_start(logic [7:0] page, bit color, bit restart);
        bit acc;
        bit was_run;
        acc = (page <= 8'hF1);
        @(negedge clk);
        was_run = exp_run;
        start_i = 1'b1;
        start_page_i = page;
        color_mode_i = color;
        @(negedge clk);
        start_i = 1'b0;
        if (acc) begin
            exp_run = 1'b1;
            exp_n = 0;
            exp_page = page;
            exp_color = color;
            exp_restart = restart;
            base = tick_cnt;
        end
        #1;
        check(busy_o == (acc || was_run), acc ? "R1" : "R1", "busy after start",
              int'(busy_o), int'(acc || was_run));
    endtask

    task automatic probe(logic [15:0] a);
        bit blk;
        string req;
        @(negedge clk);
        cpu_addr_i = a;
        cpu_rd_i = 1'($urandom);
        cpu_wr_i = 1'($urandom);
        cpu_rdata_i = 8'($urandom);
        color_mode_i = 1'($urandom);
        #1;
        blk = exp_run && exp_block(exp_page, exp_color, a);
        if (blk && a[15:8] == 8'hFE) req = "R7";
        else if (exp_run && (exp_color != color_mode_i)) req = "R10";
        else if (exp_run) req = exp_color ? "R9" : "R8";
        else req = "R6";
        check(cpu_rd_o == (cpu_rd_i && !blk), req, "cpu read strobe", int'(cpu_rd_o),
              int'(cpu_rd_i && !blk));
        check(cpu_wr_o == (cpu_wr_i && !blk), req, "cpu write strobe", int'(cpu_wr_o),
              int'(cpu_wr_i && !blk));
        check(cpu_rdata_o == (blk ? 8'hFF : cpu_rdata_i), req, "cpu read data",
              int'(cpu_rdata_o), int'(blk ? 8'hFF : cpu_rdata_i));
    endtask

    task automatic wait_done();
        while (exp_run) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        check(busy_o == 1'b0, "R5", "idle after copy", int'(busy_o), 0);
    endtask

    localparam logic [15:0] EDGES [14] = '{16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000,
        16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000, 16'hFDFF, 16'hFE00, 16'hFE9F,
        16'hFEFF, 16'hFF00, 16'hFF80};

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1;
        check(busy_o == 1'b0, "R5", "reset busy", int'(busy_o), 0);
        check(spr_we_o == 1'b0, "R4", "reset write strobe", int'(spr_we_o), 0);
        check(mem_rd_en_o == 1'b0, "R1", "reset read strobe", int'(mem_rd_en_o), 0);
        rst_n = 1'b1;

        // every region under both models
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 8; r++) begin
                logic [7:0] pg;
                pg = (r == 7) ? 8'(8'hE0 + ($urandom % 18)) : 8'(r * 32 + ($urandom % 32));
                dense = ((r % 2) == 0);
                do_start(pg, c[0], 1'b0);
                foreach (EDGES[i]) probe(EDGES[i]);
                for (int k = 0; k < 8; k++) probe(16'($urandom));
                wait_done();
                probe(16'hFE10);
                probe(16'($urandom));
            end
        end

        // limit pages: 0xF1 accepted, 0x00 accepted
        dense = 1'b1;
        do_start(8'hF1, 1'b1, 1'b0);
        probe(16'hFE40);
        wait_done();
        do_start(8'h00, 1'b0, 1'b0);
        wait_done();

        // R1: rejected pages while idle
        do_start(8'hF2, 1'b0, 1'b0);
        do_start(8'hFF, 1'b1, 1'b0);
        repeat (40) @(negedge clk);
        #1;
        check(busy_o == 1'b0, "R1", "rejected start stays idle", int'(busy_o), 0);

        // R1: rejected page during a copy leaves it untouched
        dense = 1'b0;
        do_start(8'h40, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        do_start(8'hF5, 1'b1, 1'b0);
        probe(16'hA000);
        wait_done();

        // R11: restart mid copy, under thinned and dense ticks
        do_start(8'h20, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        do_start(8'h90, 1'b0, 1'b1);
        probe(16'h9000);
        probe(16'hC000);
        wait_done();
        dense = 1'b1;
        do_start(8'hC3, 1'b1, 1'b0);
        repeat (37) @(negedge clk);
        do_start(8'hD7, 1'b1, 1'b1);
        probe(16'hE123);
        wait_done();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule